// File: doc/BRIEF.md
# Register Busy-Bit Scoreboard

This block guards an in-order five-stage integer pipeline against read-after-write hazards on the register file. It holds one pending-write flag for each architectural register. Decode offers the instruction it is holding: two source register numbers, each with its own use flag, a destination number with a writes-register flag, and an instruction-valid flag. Write-back offers the register it writes this cycle and a write enable. The block answers with a single stall signal that keeps the instruction in decode until every source it actually reads is free.

A flag is raised when an instruction leaves decode, which means it is valid and not stalled. It is dropped when write-back writes that register. The register file writes in the first half of a cycle and reads in the second half, so a register that write-back releases in a cycle is already free to a reader in decode during that same cycle. A load followed by a dependent instruction therefore stalls the consumer for two cycles rather than three. Register 0 always reads as zero and never takes part in tracking.

The stall is a plain control output and not a stream handshake. Decode holds its inputs steady while the stall is high. An instruction leaves decode on any clock edge where the valid flag is high and the stall is low. There is no other back-pressure.

Top module: `reg_busy_scoreboard`

## Requirements
- R1: Reset clears every busy flag, so after reset no source register causes a stall.
- R2: Each architectural register (1 to NREGS-1) has its own flag. A pending write to one register never stalls a reader of a different register.
- R3: An instruction that leaves decode with its writes-register flag high marks its destination busy from the next cycle on. A later reader of that register stalls.
- R4: A valid instruction that is stalled does not mark its destination busy. Only the cycle in which it leaves decode does so.
- R5: A write-back with its enable high clears the flag of the written register. That register no longer stalls readers in later cycles.
- R6: A register that write-back clears in a cycle does not stall a reader in decode in that same cycle. This holds on either source port.
- R7: Register 0 is never marked busy and never causes a stall, whether it is used as a destination or as a source.
- R8: If write-back clears a register in the same cycle that a leaving instruction marks it, the register stays busy.
- R9: A source whose use flag is low never causes a stall, even when its register number is busy.
- R10: With the instruction-valid flag low, the stall is low and no destination is marked.
- R11: When a load leaves decode in cycle t, a consumer of its destination presented in cycle t+1 stalls in cycles t+1 and t+2. It leaves decode in cycle t+3, which is the load's write-back cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_src1_idx | input | IDX_W | First source register number |
| id_src1_use | input | 1 | First source is read by the instruction |
| id_src2_idx | input | IDX_W | Second source register number |
| id_src2_use | input | 1 | Second source is read by the instruction |
| id_dst_idx | input | IDX_W | Destination register number |
| id_dst_wr | input | 1 | Instruction writes its destination |
| wb_dst_idx | input | IDX_W | Register written by write-back this cycle |
| wb_wr_en | input | 1 | Write-back writes a register this cycle |
| id_stall | output | 1 | Hold the decode instruction this cycle |

## Verification
The main function is driven with a load followed by a dependent reader. This pattern separates a design that releases at the write-back cycle from one that waits a cycle longer or does not wait at all. Readers of other registers, masked sources and register 0 show that unrelated or unused operands never hold decode. A stalled instruction that is then replaced shows whether marking happens on entry or on exit. Coincident set and clear of one register shows which one takes priority. A sweep that marks every register and then releases each one under a simultaneous reader shows that the flags are independent and that the same-cycle release works.

// File: rtl/reg_sb_pkg.sv
package reg_sb_pkg;
  // number of source operand ports checked in decode
  localparam int unsigned NUM_SRC = 2;
  typedef enum logic [0:0] {SRC_A = 1'b0, SRC_B = 1'b1} src_slot_e;
endpackage

// File: rtl/rsb_idx_decode.sv
module rsb_idx_decode #(
  parameter int unsigned NREGS   = 32,
  parameter bit          ZERO_HW = 1'b1,
  localparam int unsigned IDX_W  = $clog2(NREGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             en,
  output logic [NREGS-1:0] onehot
);
  always_comb begin
    onehot = '0;
    if (en) onehot[idx] = 1'b1;
    if (ZERO_HW) onehot[0] = 1'b0;
  end
endmodule

// File: rtl/rsb_busy_vec.sv
module rsb_busy_vec #(
  parameter int unsigned NREGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREGS-1:0] set_mask,
  input  logic [NREGS-1:0] clr_mask,
  output logic [NREGS-1:0] busy_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~clr_mask) | set_mask;
  end

  // R8
  set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & clr_mask) != '0) |=>
      ((busy_q & $past(set_mask & clr_mask)) == $past(set_mask & clr_mask)));

  // R5
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_mask) != '0) |=>
      ((busy_q & $past(clr_mask & ~set_mask)) == '0));

  // R7
  zero_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q[0]);
endmodule

// File: rtl/rsb_src_check.sv
module rsb_src_check #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] busy_view,
  input  logic [IDX_W-1:0] idx,
  input  logic             used,
  output logic             hit
);
  assign hit = used & busy_view[idx];

  // R9
  unused_quiet_chk: assert final (used || !hit);
endmodule

// File: rtl/reg_busy_scoreboard.sv
module reg_busy_scoreboard #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [IDX_W-1:0] id_src1_idx,
  input  logic             id_src1_use,
  input  logic [IDX_W-1:0] id_src2_idx,
  input  logic             id_src2_use,
  input  logic [IDX_W-1:0] id_dst_idx,
  input  logic             id_dst_wr,
  input  logic [IDX_W-1:0] wb_dst_idx,
  input  logic             wb_wr_en,
  output logic             id_stall
);
  import reg_sb_pkg::*;

  logic [NREGS-1:0] busy_q;
  logic [NREGS-1:0] set_mask;
  logic [NREGS-1:0] clr_mask;
  logic [NREGS-1:0] busy_view;
  logic [NUM_SRC-1:0] src_hit;
  logic [IDX_W-1:0] src_idx [NUM_SRC];
  logic [NUM_SRC-1:0] src_use;
  logic issue;

  assign src_idx[SRC_A] = id_src1_idx;
  assign src_idx[SRC_B] = id_src2_idx;
  assign src_use[SRC_A] = id_src1_use;
  assign src_use[SRC_B] = id_src2_use;

  // write-back release, first half of the cycle
  rsb_idx_decode #(.NREGS(NREGS), .ZERO_HW(1'b1)) u_clr_dec (
    .idx(wb_dst_idx), .en(wb_wr_en), .onehot(clr_mask)
  );

  // decode-exit marking
  rsb_idx_decode #(.NREGS(NREGS), .ZERO_HW(1'b1)) u_set_dec (
    .idx(id_dst_idx), .en(issue & id_dst_wr), .onehot(set_mask)
  );

  rsb_busy_vec #(.NREGS(NREGS)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .busy_q(busy_q)
  );

  // readers in the second half see this cycle's release
  assign busy_view = busy_q & ~clr_mask;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rsb_src_check #(.NREGS(NREGS)) u_chk (
      .busy_view(busy_view), .idx(src_idx[s]), .used(src_use[s]),
      .hit(src_hit[s])
    );
  end

  assign id_stall = id_valid & (|src_hit);
  assign issue    = id_valid & ~id_stall;

  // R10
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall |-> id_valid);

  // R9
  stall_needs_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall |-> (id_src1_use || id_src2_use));

  // R4
  stalled_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_stall && !wb_wr_en) |=> (busy_q == $past(busy_q)));

  // R3
  exit_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_stall && id_dst_wr && (id_dst_idx != '0)) |=>
      busy_q[$past(id_dst_idx)]);

  // R6
  same_cycle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wr_en && id_src1_use && (id_src1_idx == wb_dst_idx) &&
     (!id_src2_use || !busy_q[id_src2_idx])) |-> !id_stall);
endmodule

// File: tb/reg_busy_scoreboard_tb_top.sv
module reg_busy_scoreboard_tb_top;
  localparam int unsigned NREGS = 32;
  localparam int unsigned IDX_W = $clog2(NREGS);

  typedef struct packed {
    logic       v;
    logic [4:0] s1;
    logic       u1;
    logic [4:0] s2;
    logic       u2;
    logic [4:0] d;
    logic       dw;
    logic [4:0] wbd;
    logic       wbe;
    logic       exp;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 18;
  // fields: v s1 u1 s2 u2 d dw wbd wbe exp req
  localparam row_t TBL [NROWS] = '{
    '{1'b1,5'd1,1'b1,5'd2,1'b1,5'd2,1'b1,5'd0,1'b0,1'b0,4'd1},   // R1 load r2 leaves (t)
    '{1'b1,5'd2,1'b1,5'd0,1'b0,5'd4,1'b1,5'd0,1'b0,1'b1,4'd11},  // R11 t+1 stall
    '{1'b1,5'd2,1'b1,5'd0,1'b0,5'd4,1'b1,5'd0,1'b0,1'b1,4'd11},  // R11 t+2 stall
    '{1'b1,5'd2,1'b1,5'd0,1'b0,5'd4,1'b1,5'd2,1'b1,1'b0,4'd6},   // R6 t+3 leaves
    '{1'b1,5'd4,1'b1,5'd2,1'b1,5'd0,1'b0,5'd0,1'b0,1'b1,4'd3},   // R3 r4 now busy
    '{1'b1,5'd2,1'b1,5'd4,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd9},   // R9 r4 masked, R5 r2 free
    '{1'b1,5'd3,1'b1,5'd5,1'b1,5'd0,1'b1,5'd0,1'b0,1'b0,4'd2},   // R2 other regs free
    '{1'b1,5'd0,1'b1,5'd0,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0,4'd7},   // R7 r0 never busy
    '{1'b0,5'd4,1'b1,5'd0,1'b0,5'd6,1'b1,5'd0,1'b0,1'b0,4'd10},  // R10 invalid
    '{1'b1,5'd6,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd10},  // R10 r6 unmarked
    '{1'b1,5'd1,1'b1,5'd0,1'b0,5'd4,1'b1,5'd4,1'b1,1'b0,4'd8},   // R8 set+clear r4
    '{1'b1,5'd4,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b1,4'd8},   // R8 r4 still busy
    '{1'b1,5'd1,1'b0,5'd4,1'b1,5'd0,1'b0,5'd4,1'b1,1'b0,4'd6},   // R6 via second source
    '{1'b1,5'd4,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd5},   // R5 r4 released
    '{1'b1,5'd8,1'b0,5'd0,1'b0,5'd10,1'b1,5'd0,1'b0,1'b0,4'd3},  // R3 mark r10
    '{1'b1,5'd10,1'b1,5'd0,1'b0,5'd11,1'b1,5'd0,1'b0,1'b1,4'd4}, // R4 stalled, dst r11
    '{1'b1,5'd11,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd4},  // R4 r11 unmarked
    '{1'b1,5'd10,1'b1,5'd0,1'b0,5'd0,1'b0,5'd10,1'b1,1'b0,4'd6}  // R6 release r10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid = 1'b0, id_src1_use = 1'b0, id_src2_use = 1'b0, id_dst_wr = 1'b0, wb_wr_en = 1'b0;
  logic [IDX_W-1:0] id_src1_idx = '0, id_src2_idx = '0, id_dst_idx = '0, wb_dst_idx = '0;
  logic id_stall;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reg_busy_scoreboard #(.NREGS(NREGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
    .id_src1_idx(id_src1_idx), .id_src1_use(id_src1_use),
    .id_src2_idx(id_src2_idx), .id_src2_use(id_src2_use),
    .id_dst_idx(id_dst_idx), .id_dst_wr(id_dst_wr),
    .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en), .id_stall(id_stall)
  );

  task automatic drive(input logic v, input int s1, input logic u1, input int s2,
                       input logic u2, input int d, input logic dw, input int wbd,
                       input logic wbe);
    @(negedge clk);
    id_valid = v; id_src1_idx = IDX_W'(s1); id_src1_use = u1;
    id_src2_idx = IDX_W'(s2); id_src2_use = u2;
    id_dst_idx = IDX_W'(d); id_dst_wr = dw;
    wb_dst_idx = IDX_W'(wbd); wb_wr_en = wbe;
    #1;
  endtask

  task automatic check(input logic exp, input string req);
    n_cmp++;
    if (id_stall !== exp) begin
      n_bad++;
      $display("FAIL %s: stall actual %b expected %b", req, id_stall, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing busy after reset
    for (int r = 0; r < NREGS; r++) begin
      drive(1'b1, r, 1'b1, r, 1'b1, 0, 1'b0, 0, 1'b0);
      check(1'b0, "R1");
    end
    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].v, TBL[i].s1, TBL[i].u1, TBL[i].s2, TBL[i].u2,
            TBL[i].d, TBL[i].dw, TBL[i].wbd, TBL[i].wbe);
      n_cmp++;
      if (id_stall !== TBL[i].exp) begin
        n_bad++;
        $display("FAIL R%0d row %0d: stall actual %b expected %b",
                 TBL[i].req, i, id_stall, TBL[i].exp);
      end
    end
    // R2: mark every register, then each one stalls its own reader
    for (int r = 1; r < NREGS; r++) begin
      drive(1'b1, 0, 1'b0, 0, 1'b0, r, 1'b1, 0, 1'b0);
      check(1'b0, "R2");
    end
    for (int r = 1; r < NREGS; r++) begin
      drive(1'b1, r, 1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b0);
      check(1'b1, "R2");
    end
    // R6: release each one under a same-cycle reader; R5: later free
    for (int r = 1; r < NREGS; r++) begin
      drive(1'b1, r, 1'b1, 0, 1'b0, 0, 1'b0, r, 1'b1);
      check(1'b0, "R6");
      if (r < NREGS - 1) begin
        drive(1'b1, r + 1, 1'b1, r, 1'b1, 0, 1'b0, 0, 1'b0);
        check(1'b1, "R2");
      end
    end
    // R1: reset in mid-run clears marks
    drive(1'b1, 0, 1'b0, 0, 1'b0, 5, 1'b1, 0, 1'b0);
    drive(1'b1, 5, 1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b0);
    check(1'b1, "R3");
    drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 5, 1'b1, 5, 1'b1, 0, 1'b0, 0, 1'b0);
    check(1'b0, "R1");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule